// File: doc/BRIEF.md
# Bus-Idle Gated System Reset Sequencer

This block turns an active-low reset request from a board pin into an internal system reset pulse. The raw request is first brought into the clock domain by two flip-flops. It must then stay asserted for a full debounce window, counted in timebase ticks, before it can have any effect. A request that is released sooner is discarded.

A request that survives the debounce does not always cut the system off at once. If the SMBus-idle flag is high, the reset pulse starts immediately. If a transaction is in flight, the block waits for the flag to rise. A tick-counted timeout bounds that wait; with a 1 ms tick the default is 25 ms, and any timebase within ±2 ms of that is acceptable. When the timeout runs out, the reset is forced regardless of the bus.

The pulse lasts a programmed number of ticks. After it, the block waits for the pin to be released before it will accept another request. A status output records whether the most recent reset was taken on an idle bus or was forced by the timeout.

Top module: `sysrst_bus_gate`

## Requirements
- R1: After `rst_n` is deasserted and before any request, `sys_rst` is 0 and `forced` is 0.
- R2: `req_n` passes through a two-flop synchronizer. The synchronized request must then stay low across DEBOUNCE_TICKS `tick` pulses before any reset can start. A low level released before that count completes produces no `sys_rst`.
- R3: If `bus_idle` is 1 in the first cycle after the debounce completes, `sys_rst` rises on the next clock and `forced` becomes 0.
- R4: If `bus_idle` is 0 when the debounce completes, `sys_rst` stays 0 until `bus_idle` is seen high. `sys_rst` then rises on the next clock with `forced` = 0.
- R5: If `bus_idle` stays 0 through TIMEOUT_TICKS `tick` pulses of waiting, `sys_rst` rises on the next clock with `forced` = 1.
- R6: If `bus_idle` rises in the same cycle as the tick that would end the timeout, the idle bus takes priority and `forced` = 0.
- R7: Once `sys_rst` is high it stays high until PULSE_TICKS `tick` pulses have been counted. It falls on the clock after the last of them, whatever `req_n` and `bus_idle` do in the meantime.
- R8: After the pulse ends, no further reset starts while the request is still held. A new reset needs the pin to be released and then asserted again with a full debounce.
- R9: `forced` changes only in the cycle that `sys_rst` rises, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| req_n | input | 1 | Raw active-low system reset request from the pin |
| bus_idle | input | 1 | High when the SMBus has no transaction in flight |
| tick | input | 1 | One-cycle timebase strobe for all tick counts |
| sys_rst | output | 1 | Internal system reset pulse, active high |
| forced | output | 1 | 1 if the last reset was forced by the timeout, 0 if taken on an idle bus |

## Verification
The bus becoming idle and the final timeout tick can land in the same cycle, and they call for opposite values of `forced`. The bench provokes this collision by watching its reference model. When the model is one tick short of the timeout, the bench raises `bus_idle` in exactly the cycle it drives that tick. The outcome is judged by requiring `forced` = 0 on the resulting pulse, with the model compared every clock. A second overlap is a glitch release that coincides with a debounce tick. The per-cycle comparison against the model judges that case as well.

// File: rtl/sysrst_bus_gate.sv
module sysrst_bus_gate #(
  parameter int DEBOUNCE_TICKS = 16,
  parameter int TIMEOUT_TICKS  = 25,
  parameter int PULSE_TICKS    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  input  logic bus_idle,
  input  logic tick,
  output logic sys_rst,
  output logic forced
);

  localparam int MAX_A  = (DEBOUNCE_TICKS > TIMEOUT_TICKS) ? DEBOUNCE_TICKS : TIMEOUT_TICKS;
  localparam int MAX_T  = (MAX_A > PULSE_TICKS) ? MAX_A : PULSE_TICKS;
  localparam int CW     = $clog2(MAX_T + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_DEBOUNCE, S_WAIT_BUS, S_ASSERT, S_HOLD
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          sync1, req_s;
  logic [CW-1:0] limit;
  logic          at_limit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= 1'b0;
      req_s <= 1'b0;
    end else begin
      sync1 <= ~req_n;
      req_s <= sync1;
    end

  always_comb
    case (state)
      S_DEBOUNCE: limit = CW'(DEBOUNCE_TICKS - 1);
      S_WAIT_BUS: limit = CW'(TIMEOUT_TICKS - 1);
      default:    limit = CW'(PULSE_TICKS - 1);
    endcase

  assign at_limit = tick && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      forced <= 1'b0;
    end else begin
      case (state)
        S_IDLE:
          if (req_s) begin
            state <= S_DEBOUNCE;
            cnt   <= '0;
          end
        S_DEBOUNCE:
          if (!req_s)
            state <= S_IDLE;
          else if (at_limit) begin
            state <= S_WAIT_BUS;
            cnt   <= '0;
          end else if (tick)
            cnt <= cnt + 1'b1;
        S_WAIT_BUS:
          if (bus_idle || at_limit) begin
            state  <= S_ASSERT;
            forced <= !bus_idle;
            cnt    <= '0;
          end else if (tick)
            cnt <= cnt + 1'b1;
        S_ASSERT:
          if (at_limit)
            state <= S_HOLD;
          else if (tick)
            cnt <= cnt + 1'b1;
        S_HOLD:
          if (!req_s)
            state <= S_IDLE;
        default:
          state <= S_IDLE;
      endcase
    end

  assign sys_rst = (state == S_ASSERT);

  assert_reset_needs_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(req_s) || $past(state) == S_WAIT_BUS);

  assert_glitch_no_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEBOUNCE && !req_s) |=> !sys_rst);

  assert_idle_starts_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT_BUS && bus_idle) |=> (sys_rst && !forced));

  assert_force_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sys_rst) && forced) |-> !$past(bus_idle));

  assert_idle_wins_collision_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT_BUS && bus_idle && tick) |=> !forced);

  assert_pulse_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && !tick) |=> sys_rst);

  assert_hold_no_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD) |=> !sys_rst);

  assert_forced_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_rst && !$past(sys_rst)) |-> $stable(forced));

endmodule

// File: tb/sysrst_bus_gate_bench.sv
module sysrst_bus_gate_bench;
  localparam int DEB = 4;
  localparam int TMO = 10;
  localparam int PW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_n = 1'b1;
  logic idle_drv = 1'b1;
  logic collide_idle = 1'b0;
  logic collide_arm = 1'b0;
  logic collide_seen = 1'b0;
  logic tick = 1'b0;
  logic bus_idle;
  logic sys_rst, forced;

  int checks = 0, errors = 0, cycles = 0;
  int tcnt = 0;
  int resets = 0, width = 0, last_width = 0;
  logic prev_rst = 1'b0;

  int m_ph = 0, m_cnt = 0;
  logic m_s1 = 1'b0, m_s2 = 1'b0, m_rst = 1'b0, m_forced = 1'b0;

  assign bus_idle = idle_drv | collide_idle;

  always #10 clk = ~clk;

  sysrst_bus_gate #(.DEBOUNCE_TICKS(DEB), .TIMEOUT_TICKS(TMO), .PULSE_TICKS(PW)) u_sysrst_bus_gate (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .bus_idle(bus_idle), .tick(tick),
    .sys_rst(sys_rst), .forced(forced));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_s1 = 0; m_s2 = 0; m_forced = 0;
    end else begin
      case (m_ph)
        0: if (m_s2) begin m_ph = 1; m_cnt = 0; end
        1: if (!m_s2) m_ph = 0;
           else if (tick) begin
             if (m_cnt == DEB - 1) begin m_ph = 2; m_cnt = 0; end
             else m_cnt++;
           end
        2: if (bus_idle) begin m_ph = 3; m_forced = 0; m_cnt = 0; end
           else if (tick) begin
             if (m_cnt == TMO - 1) begin m_ph = 3; m_forced = 1; m_cnt = 0; end
             else m_cnt++;
           end
        3: if (tick) begin
             if (m_cnt == PW - 1) m_ph = 4;
             else m_cnt++;
           end
        default: if (!m_s2) m_ph = 0;
      endcase
      m_s2 = m_s1;
      m_s1 = ~req_n;
    end
    m_rst = (m_ph == 3);
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(sys_rst === m_rst, "R3 R4 R5 R7 sys_rst vs model", sys_rst, m_rst);
      check(forced === m_forced, "R9 forced vs model", forced, m_forced);
      if (sys_rst && !prev_rst) resets++;
      if (sys_rst) width++;
      if (!sys_rst && prev_rst) begin last_width = width; width = 0; end
      prev_rst = sys_rst;
    end
    tcnt = (tcnt == 2) ? 0 : tcnt + 1;
    tick = (tcnt == 0);
    if (collide_arm && !collide_idle && m_ph == 2 && m_cnt == TMO - 1 && tick) begin
      collide_idle = 1'b1;
      collide_seen = 1'b1;
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic press(input int n);
    req_n = 1'b0;
    wait_cyc(n);
    req_n = 1'b1;
    wait_cyc(20);
  endtask

  initial begin
    int r0;
    wait_cyc(3);
    check(sys_rst === 1'b0, "R1 sys_rst in reset", sys_rst, 0);
    rst_n = 1'b1;
    wait_cyc(2);
    check(sys_rst === 1'b0, "R1 sys_rst after reset", sys_rst, 0);
    check(forced === 1'b0, "R1 forced after reset", forced, 0);

    r0 = resets;
    press(6);
    check(resets == r0, "R2 short glitch gives no reset", resets - r0, 0);
    press(11);
    check(resets == r0, "R2 near-window glitch gives no reset", resets - r0, 0);

    r0 = resets;
    idle_drv = 1'b1;
    press(60);
    check(resets == r0 + 1, "R3 idle bus reset count", resets - r0, 1);
    check(forced === 1'b0, "R3 idle bus not forced", forced, 0);
    check(last_width >= (PW - 1) * 3 + 1 && last_width <= PW * 3, "R7 pulse width", last_width, PW * 3);
    check(resets == r0 + 1, "R8 held request no second reset", resets - r0, 1);

    r0 = resets;
    idle_drv = 1'b0;
    req_n = 1'b0;
    wait_cyc(30);
    check(resets == r0, "R4 no reset while bus busy", resets - r0, 0);
    idle_drv = 1'b1;
    wait_cyc(3);
    check(sys_rst === 1'b1, "R4 reset after idle", sys_rst, 1);
    check(forced === 1'b0, "R4 not forced", forced, 0);
    req_n = 1'b1;
    wait_cyc(30);

    r0 = resets;
    idle_drv = 1'b0;
    press(70);
    check(resets == r0 + 1, "R5 timeout reset count", resets - r0, 1);
    check(forced === 1'b1, "R5 forced after timeout", forced, 1);
    check(last_width >= (PW - 1) * 3 + 1 && last_width <= PW * 3, "R7 forced pulse width", last_width, PW * 3);
    idle_drv = 1'b1;
    wait_cyc(10);
    check(forced === 1'b1, "R9 forced holds between resets", forced, 1);

    r0 = resets;
    idle_drv = 1'b0;
    collide_arm = 1'b1;
    press(70);
    check(collide_seen === 1'b1, "R6 collision provoked", collide_seen, 1);
    check(resets == r0 + 1, "R6 collision reset count", resets - r0, 1);
    check(forced === 1'b0, "R6 idle wins over timeout", forced, 0);
    collide_arm = 1'b0;
    collide_idle = 1'b0;
    idle_drv = 1'b1;
    wait_cyc(5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule